// File: doc/BRIEF.md
# Configurable GPIO Port Cell

This block controls a single general-purpose I/O pin from one 8-bit configuration byte. The byte picks whether the pin is an input or an output, whether its data is inverted, and whether an output drives actively both ways (push-pull) or only pulls low (open-drain). It also picks whether the pin serves as plain GPIO or hands over to one of three predefined alternate functions, and whether the pin feeds its group interrupt.

A host writes the configuration byte and the output data bit through a simple write strobe. It reads back the configuration byte and the pin level after polarity. The configuration byte can only change while the configuration-mode input is high.

The pad is modelled as an output-enable, an output value and an input value. The input value passes through a synchronizer before any other use. Alternate-function logic connects through generic per-function value, direction and input ports. Combining interrupts across pins is done outside this block.

Top module: `gpio_port_cell`

## Requirements
- R1: After reset the configuration byte reads 0x01 (plain GPIO input, non-inverted, interrupt disabled), the output data bit is 0 and `pad_oe` is 0.
- R2: A write with `wr_sel`=0 loads `wr_data` into the configuration byte only while `cfg_mode` is 1. Such a write while `cfg_mode` is 0 leaves `rd_cfg` unchanged. A write with `wr_sel`=1 loads `wr_data[0]` into the output data bit regardless of `cfg_mode`.
- R3: With configuration bits 4:3 = 00, bit 0 sets the direction. A 1 means input, so `pad_oe`=0. A 0 means output, and the pin drives the data bit XOR bit 1.
- R4: Configuration bit 1 = 1 inverts the driven value, and it inverts the pin level seen on `rd_pin` and on `irq_src`.
- R5: Configuration bit 7 = 0 selects push-pull: when the pin is an output, `pad_oe`=1 and `pad_o` is the driven value. Bit 7 = 1 selects open-drain: `pad_o`=0, and `pad_oe` is 1 only while the driven value is 0. This holds for GPIO and for alternate outputs alike.
- R6: Configuration bits 4:3 = k (1 to 3) select alternate function k. Direction then comes from `alt_dir_in[k-1]` (1 = input), and bit 0 is ignored. The driven value is `alt_out[k-1]` XOR bit 1.
- R7: The selected alternate function receives the synchronized pin XOR bit 1 on its `alt_in` bit. Functions marked in `ALT_NOINV` are never inverted (default: function 3).
- R8: Every `alt_in` bit whose function is not selected is held at 1.
- R9: `irq_src` equals configuration bit 5 AND the pin level after polarity.
- R10: A change on `pad_i` reaches `rd_pin` after exactly `SYNC_STAGES` rising clock edges (2 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | Configuration mode; allows configuration byte writes |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = configuration byte, 1 = output data bit |
| wr_data | input | 8 | Write data |
| rd_cfg | output | 8 | Configuration byte read-back |
| rd_pin | output | 1 | Synchronized pin level after polarity |
| pad_i | input | 1 | Raw pad input |
| pad_oe | output | 1 | Pad output enable |
| pad_o | output | 1 | Pad output value |
| alt_out | input | 3 | Output value of each alternate function |
| alt_dir_in | input | 3 | Direction requested by each alternate function (1 = input) |
| alt_in | output | 3 | Input value delivered to each alternate function |
| irq_src | output | 1 | Pin's contribution to its group interrupt |

## Verification
The bench builds the cell with its default parameters: a two-stage synchronizer, reset byte 0x01, and only function 3 marked as non-inverting. This puts an inverted alternate input (function 1) and a non-inverted one (function 3) within reach of the same polarity setting. It also lets the two-edge input latency be checked on the exact cycle on which it applies. Open-drain release is exercised both on the GPIO data path and on an alternate output, and locked configuration writes are mixed with unlocked data writes.

// File: rtl/gpio_cell_pkg.sv
package gpio_cell_pkg;

    localparam int CFG_W   = 8;
    localparam int FSEL_W  = 2;
    localparam int NUM_ALT = (1 << FSEL_W) - 1;

    // Configuration byte layout (field positions are decoded by the cell)
    typedef struct packed {
        logic              od;      // bit 7: 1 = open-drain, 0 = push-pull
        logic              rsv6;
        logic              ien;     // bit 5: interrupt contribution enable
        logic [FSEL_W-1:0] fsel;    // bits 4:3: 0 = GPIO, k = alternate k
        logic              rsv2;
        logic              pol;     // bit 1: invert data
        logic              dir_in;  // bit 0: 1 = input, 0 = output
    } cfg_t;

    typedef enum logic {
        WSEL_CFG  = 1'b0,
        WSEL_DATA = 1'b1
    } wsel_e;

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_cell_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_CFG = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg_q,
    output logic             dout_q
);

    wsel_e sel;
    assign sel = wsel_e'(wr_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= cfg_t'(RESET_CFG);
            dout_q <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                WSEL_CFG:  if (cfg_mode) cfg_q <= cfg_t'(wr_data);
                WSEL_DATA: dout_q <= wr_data[0];
                default:   ;
            endcase
        end
    end

    // R2
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> $stable(cfg_q))
        else $error("configuration changed outside configuration mode");

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= 1'b0;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_cell_pkg::*;
(
    input  cfg_t               cfg,
    input  logic               dout,
    input  logic [NUM_ALT-1:0] alt_out,
    input  logic [NUM_ALT-1:0] alt_dir_in,
    output logic               pad_oe,
    output logic               pad_o
);

    logic [NUM_ALT:0] src_dir;
    logic [NUM_ALT:0] src_val;
    logic             is_in;
    logic             drv;

    // Index 0 is the GPIO path, index k is alternate function k
    assign src_dir = {alt_dir_in, cfg.dir_in};
    assign src_val = {alt_out, dout};

    always_comb begin
        is_in  = src_dir[cfg.fsel];
        drv    = src_val[cfg.fsel] ^ cfg.pol;
        pad_oe = !is_in && (!cfg.od || !drv);
        pad_o  = cfg.od ? 1'b0 : drv;
    end

endmodule

// File: rtl/gpio_alt_route.sv
module gpio_alt_route
    import gpio_cell_pkg::*;
#(
    parameter logic [NUM_ALT-1:0] ALT_NOINV = 3'b100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cfg_t               cfg,
    input  logic               pin_sync,
    output logic [NUM_ALT-1:0] alt_in
);

    generate
        for (genvar k = 0; k < NUM_ALT; k++) begin : g_alt
            localparam logic [FSEL_W-1:0] CODE = FSEL_W'(k + 1);
            localparam logic NOINV = ALT_NOINV[k];
            assign alt_in[k] = (cfg.fsel == CODE)
                             ? (pin_sync ^ (cfg.pol & ~NOINV))
                             : 1'b1;
        end
    endgenerate

    // R8
    alt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.fsel == '0) |-> (&alt_in))
        else $error("alternate input active while GPIO selected");

endmodule

// File: rtl/gpio_port_cell.sv
module gpio_port_cell
    import gpio_cell_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter logic [CFG_W-1:0]   RESET_CFG   = 8'h01,
    parameter logic [NUM_ALT-1:0] ALT_NOINV   = 3'b100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_mode,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [CFG_W-1:0]   wr_data,
    output logic [CFG_W-1:0]   rd_cfg,
    output logic               rd_pin,
    input  logic               pad_i,
    output logic               pad_oe,
    output logic               pad_o,
    input  logic [NUM_ALT-1:0] alt_out,
    input  logic [NUM_ALT-1:0] alt_dir_in,
    output logic [NUM_ALT-1:0] alt_in,
    output logic               irq_src
);

    cfg_t cfg_q;
    logic dout_q;
    logic pin_sync;

    gpio_cfg_regs #(.RESET_CFG(RESET_CFG)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .cfg_q(cfg_q), .dout_q(dout_q)
    );

    gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_i), .q(pin_sync)
    );

    gpio_pad_drive u_drive (
        .cfg(cfg_q), .dout(dout_q), .alt_out(alt_out),
        .alt_dir_in(alt_dir_in), .pad_oe(pad_oe), .pad_o(pad_o)
    );

    gpio_alt_route #(.ALT_NOINV(ALT_NOINV)) u_alt (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .pin_sync(pin_sync),
        .alt_in(alt_in)
    );

    assign rd_cfg  = cfg_q;
    assign rd_pin  = pin_sync ^ cfg_q.pol;
    assign irq_src = cfg_q.ien & rd_pin;

    // Cycles since reset, for the latency check window
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R3
    gpio_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.fsel == '0 && cfg_q.dir_in) |-> !pad_oe)
        else $error("pad driven while GPIO input");

    // R5
    od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.od && pad_oe) |-> !pad_o)
        else $error("open-drain pad driving high");

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.ien |-> !irq_src)
        else $error("interrupt source while disabled");

    generate
        if (SYNC_STAGES == 2) begin : g_lat_chk
            // R10
            sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst == 2'd3) |-> (rd_pin == ($past(pad_i, 2) ^ cfg_q.pol)))
                else $error("pin latency mismatch");
        end
    endgenerate

endmodule

// File: tb/sim_gpio_port_cell.sv
module sim_gpio_port_cell;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] NOINV = 3'b100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_cfg;
    logic       rd_pin;
    logic       pad_i = 1'b0;
    logic       pad_oe;
    logic       pad_o;
    logic [2:0] alt_out = '0;
    logic [2:0] alt_dir_in = '0;
    logic [2:0] alt_in;
    logic       irq_src;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_cell u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_cfg(rd_cfg), .rd_pin(rd_pin),
        .pad_i(pad_i), .pad_oe(pad_oe), .pad_o(pad_o), .alt_out(alt_out),
        .alt_dir_in(alt_dir_in), .alt_in(alt_in), .irq_src(irq_src)
    );

    typedef struct {
        string       tag;
        logic [14:0] exp;
    } item_t;

    item_t q[$];
    event  sample_ev;
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    logic [7:0] cfg_m = 8'h01;
    logic       dout_m = 1'b0;
    logic       pin_m = 1'b0;

    // Expected port picture {pad_oe, pad_o, rd_pin, irq_src, alt_in, rd_cfg}
    function automatic logic [14:0] model(input logic [7:0] c, input logic d,
                                          input logic pin, input logic [2:0] ao,
                                          input logic [2:0] ad);
        logic [1:0] fs;
        logic is_in, raw, drv, oe, po, inv;
        logic [2:0] ai;
        fs = c[4:3];
        is_in = (fs == 2'd0) ? c[0] : ad[fs - 2'd1];
        raw   = (fs == 2'd0) ? d : ao[fs - 2'd1];
        drv   = raw ^ c[1];
        oe    = !is_in && (!c[7] || !drv);
        po    = c[7] ? 1'b0 : drv;
        inv   = pin ^ c[1];
        for (int k = 0; k < 3; k++)
            ai[k] = (fs == 2'(k + 1)) ? (pin ^ (c[1] & ~NOINV[k])) : 1'b1;
        return {oe, po, inv, c[5] & inv, ai, c};
    endfunction

    task automatic check(input string tag);
        item_t it;
        it.tag = tag;
        it.exp = model(cfg_m, dout_m, pin_m, alt_out, alt_dir_in);
        q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    // Monitor: pops expected items and compares to the ports
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [14:0] got;
                it = q.pop_front();
                got = {pad_oe, pad_o, rd_pin, irq_src, alt_in, rd_cfg};
                n_checks++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic write_reg(input logic sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 1'b0 && cfg_mode) cfg_m = data;
        if (sel == 1'b1) dout_m = data[0];
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        pad_i = v;
        repeat (3) @(negedge clk);
        pin_m = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state");

        // R2: locked configuration write
        write_reg(1'b0, 8'h00);
        check("R2 locked write ignored");

        cfg_mode = 1'b1;
        write_reg(1'b0, 8'h00);
        write_reg(1'b1, 8'h01);
        check("R3 output drives 1");
        write_reg(1'b1, 8'h00);
        check("R3 output drives 0");

        write_reg(1'b0, 8'h02);
        check("R4 inverted output");
        set_pin(1'b1);
        check("R4 inverted read-back");

        write_reg(1'b0, 8'h80);
        write_reg(1'b1, 8'h01);
        check("R5 open-drain release");
        write_reg(1'b1, 8'h00);
        check("R5 open-drain pull low");

        write_reg(1'b0, 8'h01);
        check("R3 input no drive");

        write_reg(1'b0, 8'h21);
        check("R9 irq pin high");
        set_pin(1'b0);
        check("R9 irq pin low");
        write_reg(1'b0, 8'h23);
        check("R9 irq inverted");

        // R6: function 1 output overrides bit 0 = input
        alt_dir_in = 3'b110; alt_out = 3'b001;
        write_reg(1'b0, 8'h09);
        check("R6 alt direction override");
        check("R8 unselected alt idle");

        // R7: function 1 inverted, function 3 not inverted
        alt_dir_in = 3'b111;
        write_reg(1'b0, 8'h0A);
        set_pin(1'b1);
        check("R7 alt input inverted");
        write_reg(1'b0, 8'h1A);
        check("R7 alt input noinv");

        // R6/R5: function 2 open-drain output
        alt_dir_in = 3'b101; alt_out = 3'b010;
        write_reg(1'b0, 8'h90);
        check("R6 alt open-drain release");
        alt_out = 3'b000;
        @(negedge clk);
        check("R6 alt open-drain low");

        // R10: two-edge latency
        write_reg(1'b0, 8'h01);
        set_pin(1'b0);
        pad_i = 1'b1;
        @(negedge clk);
        check("R10 after one edge");
        @(negedge clk);
        pin_m = 1'b1;
        check("R10 after two edges");

        // R2: data write accepted outside configuration mode, config locked
        cfg_mode = 1'b0;
        write_reg(1'b0, 8'h00);
        write_reg(1'b1, 8'h01);
        check("R2 locked again");
        cfg_mode = 1'b1;
        write_reg(1'b0, 8'h00);
        check("R2 data kept while locked");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule